// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block keeps a pending-request vector for each of a set of priority levels. Each vector is one bit per source. It also keeps a one-bit-per-level status word that tells which levels have work waiting. Requesters post or clear single sources by level and source index. A clear-all command empties every vector at once.

Each cycle the block merges two inputs into one resolved priority and one summary mask. The first is the software request word, restricted to the software band. The second is the status word, restricted to the external band. It raises an interrupt towards the core only when that priority is above the core's current priority level. The core sees a one-cycle-registered take strobe together with the interrupt identifier and the summary mask.

An asynchronous-trap request is not serviced and is only reported as an error. Malformed post or clear commands are refused and leave a sticky error flag behind.

Top module: `lvl_irq_prio_ctrl`

## Requirements
- R1: After reset all pending vectors and the status word are zero, and takeIrq, irqId, irqSummary, anyPending, astErr and cmdErr are all 0.
- R2: A legal post of (level L, source S) sets bit S of level L's vector and status bit L at the next clock edge, so anyPending and levelBusy (with queryLevel = L) read 1 right after that edge.
- R3: A legal clear of (L, S) removes bit S from level L's vector. Status bit L falls only when that vector has become all zero; otherwise levelBusy and anyPending stay 1.
- R4: Clear-all zeros every vector and the status word at the next edge, and it wins over a post or clear issued in the same cycle.
- R5: When post and clear address the same level and source in the same cycle, the post wins and the bit ends up set.
- R6: Each set bit i of swReq with 1 <= i <= 15 contributes priority i (bit index minus 1, plus 1) and sets bit i of the summary mask. swReq bit 0 and bits 16..31 have no effect.
- R7: Each set status bit i with 16 <= i <= 31 contributes priority i and sets summary bit i. The resolved priority is the highest contributing index, so any pending external level overrides every software bit. Status bits 0..15 never contribute.
- R8: The interrupt fires only when the resolved priority is nonzero and strictly greater than curIpl. When it fires, irqId takes the priority and irqSummary takes the mask; otherwise both hold their previous values.
- R9: astReq is never serviced. astErr shows astReq delayed by one clock, and astReq does not block or cause takeIrq.
- R10: A post or clear with cmdLevel >= 32 or cmdSource >= 64 changes no state and sets cmdErr, which stays 1 until reset.
- R11: takeIrq, irqId and irqSummary are registered: they reflect the state and inputs of the cycle before the clock edge, so a post shows on takeIrq two edges after it is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdPost | input | 1 | Post the addressed source |
| cmdClear | input | 1 | Clear the addressed source |
| cmdClearAll | input | 1 | Empty every level |
| cmdLevel | input | 6 | Command level index (values >= 32 illegal) |
| cmdSource | input | 7 | Command source index (values >= 64 illegal) |
| queryLevel | input | 5 | Level whose vector drives levelBusy |
| swReq | input | 32 | Software interrupt request word |
| astReq | input | 1 | Asynchronous-trap request (unsupported) |
| curIpl | input | 5 | Current priority level of the core |
| anyPending | output | 1 | Status word nonzero |
| levelBusy | output | 1 | Vector of queryLevel nonzero |
| takeIrq | output | 1 | Interrupt taken this cycle |
| irqId | output | 5 | Resolved priority of the last taken interrupt |
| irqSummary | output | 32 | Summary mask of the last taken interrupt |
| astErr | output | 1 | astReq seen in the previous cycle |
| cmdErr | output | 1 | Sticky illegal-command flag |

## Verification
Post and clear share one address, so both can hit the same level and source in the same cycle. The bench drives both strobes together and then clears a second source of that level on its own. It judges that the level is still busy, which proves the post survived. Clear-all is also driven alongside a post to a different level, and the bench checks that nothing remains pending. A table walk covers the software mapping and the strict IPL comparison. Directed steps then mix software and external requests to show that the external level overrides.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int NUM_LEVELS = 32;
  localparam int SRC_W      = 64;
  localparam int LVL_W      = $clog2(NUM_LEVELS);
  localparam int SRC_IDX_W  = $clog2(SRC_W);
  localparam int CMD_LVL_W  = LVL_W + 1;
  localparam int CMD_SRC_W  = SRC_IDX_W + 1;
  localparam int SW_MIN     = 1;
  localparam int SW_MAX     = 16;
  localparam int EXT_MIN    = 16;
  localparam int EXT_MAX    = 32;

  typedef struct packed {
    logic                 doPost;
    logic                 doClear;
    logic                 doClearAll;
    logic [LVL_W-1:0]     level;
    logic [SRC_IDX_W-1:0] source;
  } cmdStrobe_t;
endpackage

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdPost,
  input  logic                 cmdClear,
  input  logic                 cmdClearAll,
  input  logic [CMD_LVL_W-1:0] cmdLevel,
  input  logic [CMD_SRC_W-1:0] cmdSource,
  output cmdStrobe_t           strobe,
  output logic                 cmdErr
);
  logic cmdLegal;
  logic cmdIllegal;

  assign cmdLegal   = (cmdLevel < CMD_LVL_W'(NUM_LEVELS)) &&
                      (cmdSource < CMD_SRC_W'(SRC_W));
  assign cmdIllegal = (cmdPost || cmdClear) && !cmdLegal;

  always_comb begin
    strobe.doClearAll = cmdClearAll;
    strobe.doPost     = cmdPost  && cmdLegal && !cmdClearAll;
    strobe.doClear    = cmdClear && cmdLegal && !cmdClearAll;
    strobe.level      = cmdLevel[LVL_W-1:0];
    strobe.source     = cmdSource[SRC_IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmdErr <= 1'b0;
    else if (cmdIllegal) cmdErr <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |=> cmdErr); // R10
  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    cmdIllegal |=> cmdErr); // R10
endmodule

// File: rtl/lvl_irq_store.sv
module lvl_irq_store
  import lvl_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  cmdStrobe_t            strobe,
  input  logic [LVL_W-1:0]      queryLevel,
  output logic [NUM_LEVELS-1:0] levelStatus,
  output logic                  levelBusy
);
  logic [SRC_W-1:0]      vec     [NUM_LEVELS];
  logic [SRC_W-1:0]      vecNext [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] statusNext;
  logic [NUM_LEVELS-1:0] levelNonZero;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    assign levelNonZero[g] = |vec[g];
  end

  assign levelBusy = levelNonZero[queryLevel];

  always_comb begin
    vecNext    = vec;
    statusNext = levelStatus;
    if (strobe.doClearAll) begin
      for (int l = 0; l < NUM_LEVELS; l++) vecNext[l] = '0;
      statusNext = '0;
    end else begin
      if (strobe.doClear) vecNext[strobe.level][strobe.source] = 1'b0;
      if (strobe.doPost)  vecNext[strobe.level][strobe.source] = 1'b1;
      if (strobe.doPost)
        statusNext[strobe.level] = 1'b1;
      else if (strobe.doClear && (vecNext[strobe.level] == '0))
        statusNext[strobe.level] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LEVELS; l++) vec[l] <= '0;
      levelStatus <= '0;
    end else begin
      vec         <= vecNext;
      levelStatus <= statusNext;
    end
  end

  AST_CLEARALL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doClearAll |=> (levelStatus == '0)); // R4
  AST_POST_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPost |=> levelStatus[$past(strobe.level)]); // R2
  AST_CLEAR_TRACKS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doClear && !strobe.doPost && !strobe.doClearAll) |=>
      (levelStatus[$past(strobe.level)] == levelNonZero[$past(strobe.level)])); // R3
endmodule

// File: rtl/lvl_irq_resolve.sv
module lvl_irq_resolve
  import lvl_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] swReq,
  input  logic [NUM_LEVELS-1:0] levelStatus,
  input  logic [LVL_W-1:0]      curIpl,
  output logic                  takeIrq,
  output logic [LVL_W-1:0]      irqId,
  output logic [NUM_LEVELS-1:0] irqSummary
);
  logic [LVL_W-1:0]      resolvedPri;
  logic [NUM_LEVELS-1:0] summaryMask;
  logic                  fire;

  always_comb begin
    resolvedPri = '0;
    summaryMask = '0;
    for (int i = SW_MIN; i < SW_MAX; i++) begin
      if (swReq[i]) begin
        resolvedPri    = LVL_W'(i - SW_MIN + 1);
        summaryMask[i] = 1'b1;
      end
    end
    for (int i = EXT_MIN; i < EXT_MAX; i++) begin
      if (levelStatus[i]) begin
        resolvedPri    = LVL_W'(i);
        summaryMask[i] = 1'b1;
      end
    end
  end

  assign fire = (resolvedPri != '0) && (resolvedPri > curIpl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeIrq    <= 1'b0;
      irqId      <= '0;
      irqSummary <= '0;
    end else begin
      takeIrq <= fire;
      if (fire) begin
        irqId      <= resolvedPri;
        irqSummary <= summaryMask;
      end
    end
  end

  AST_FIRE_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (irqId > $past(curIpl))); // R8
  AST_ID_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (irqId != '0)); // R8
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |-> ($stable(irqId) && $stable(irqSummary))); // R8
  AST_EXT_IN_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && (irqId >= LVL_W'(EXT_MIN))) |-> irqSummary[irqId]); // R7
endmodule

// File: rtl/lvl_irq_prio_ctrl.sv
module lvl_irq_prio_ctrl
  import lvl_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdPost,
  input  logic                  cmdClear,
  input  logic                  cmdClearAll,
  input  logic [CMD_LVL_W-1:0]  cmdLevel,
  input  logic [CMD_SRC_W-1:0]  cmdSource,
  input  logic [LVL_W-1:0]      queryLevel,
  input  logic [NUM_LEVELS-1:0] swReq,
  input  logic                  astReq,
  input  logic [LVL_W-1:0]      curIpl,
  output logic                  anyPending,
  output logic                  levelBusy,
  output logic                  takeIrq,
  output logic [LVL_W-1:0]      irqId,
  output logic [NUM_LEVELS-1:0] irqSummary,
  output logic                  astErr,
  output logic                  cmdErr
);
  cmdStrobe_t            strobe;
  logic [NUM_LEVELS-1:0] levelStatus;

  lvl_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdPost(cmdPost), .cmdClear(cmdClear),
    .cmdClearAll(cmdClearAll), .cmdLevel(cmdLevel), .cmdSource(cmdSource),
    .strobe(strobe), .cmdErr(cmdErr)
  );

  lvl_irq_store u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .queryLevel(queryLevel),
    .levelStatus(levelStatus), .levelBusy(levelBusy)
  );

  lvl_irq_resolve u_resolve (
    .clk(clk), .rstN(rstN), .swReq(swReq), .levelStatus(levelStatus),
    .curIpl(curIpl), .takeIrq(takeIrq), .irqId(irqId), .irqSummary(irqSummary)
  );

  assign anyPending = |levelStatus;

  always_ff @(posedge clk) begin
    if (!rstN) astErr <= 1'b0;
    else       astErr <= astReq;
  end

  AST_AST_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    astReq |=> astErr); // R9
  AST_ILLEGAL_NOCHANGE: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdPost || cmdClear) && !cmdClearAll &&
     ((cmdLevel >= CMD_LVL_W'(NUM_LEVELS)) || (cmdSource >= CMD_SRC_W'(SRC_W))))
      |=> $stable(anyPending)); // R10
endmodule

// File: tb/lvl_irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_prio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdPost = 1'b0, cmdClear = 1'b0, cmdClearAll = 1'b0;
  logic [5:0]  cmdLevel = '0;
  logic [6:0]  cmdSource = '0;
  logic [4:0]  queryLevel = '0;
  logic [31:0] swReq = '0;
  logic        astReq = 1'b0;
  logic [4:0]  curIpl = '0;
  logic        anyPending, levelBusy, takeIrq, astErr, cmdErr;
  logic [4:0]  irqId;
  logic [31:0] irqSummary;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  lvl_irq_prio_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cmdPost(cmdPost), .cmdClear(cmdClear),
    .cmdClearAll(cmdClearAll), .cmdLevel(cmdLevel), .cmdSource(cmdSource),
    .queryLevel(queryLevel), .swReq(swReq), .astReq(astReq), .curIpl(curIpl),
    .anyPending(anyPending), .levelBusy(levelBusy), .takeIrq(takeIrq),
    .irqId(irqId), .irqSummary(irqSummary), .astErr(astErr), .cmdErr(cmdErr)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cmd(input logic p, input logic c, input logic ca,
                     input logic [5:0] lvl, input logic [6:0] src);
    cmdPost = p; cmdClear = c; cmdClearAll = ca; cmdLevel = lvl; cmdSource = src;
    tick();
    cmdPost = 1'b0; cmdClear = 1'b0; cmdClearAll = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  typedef struct packed {
    logic [31:0] sw;
    logic [4:0]  ipl;
    logic        take;
    logic [4:0]  id;
    logic [31:0] sum;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{32'h0000_0000, 5'd0,  1'b0, 5'd0,  32'h0000_0000},
    '{32'h0000_0002, 5'd0,  1'b1, 5'd1,  32'h0000_0002},
    '{32'h0000_0002, 5'd1,  1'b0, 5'd1,  32'h0000_0002},
    '{32'h0000_8002, 5'd5,  1'b1, 5'd15, 32'h0000_8002},
    '{32'h0000_8002, 5'd15, 1'b0, 5'd15, 32'h0000_8002},
    '{32'h0001_0001, 5'd0,  1'b0, 5'd15, 32'h0000_8002},
    '{32'h0000_0030, 5'd3,  1'b1, 5'd5,  32'h0000_0030},
    '{32'h0000_0010, 5'd3,  1'b1, 5'd4,  32'h0000_0010},
    '{32'h0000_0010, 5'd4,  1'b0, 5'd4,  32'h0000_0010}
  };

  initial begin
    doReset();
    // R1 reset state
    chk("R1 takeIrq", takeIrq, 0);
    chk("R1 irqId", irqId, 0);
    chk("R1 irqSummary", irqSummary, 0);
    chk("R1 anyPending", anyPending, 0);
    chk("R1 errors", {astErr, cmdErr}, 0);

    // R6 / R8 table walk: software mapping and strict IPL compare
    for (int k = 0; k < 9; k++) begin
      swReq = TBL[k].sw;
      curIpl = TBL[k].ipl;
      tick();
      chk($sformatf("R6 R8 row%0d take", k), takeIrq, TBL[k].take);
      chk($sformatf("R6 R8 row%0d id", k), irqId, TBL[k].id);
      chk($sformatf("R6 R8 row%0d sum", k), irqSummary, TBL[k].sum);
    end

    doReset();
    swReq = '0; curIpl = '0;
    queryLevel = 5'd20;
    cmd(1, 0, 0, 6'd20, 7'd63);
    chk("R2 anyPending after post", anyPending, 1);
    chk("R2 levelBusy after post", levelBusy, 1);
    chk("R11 take not yet", takeIrq, 0);
    tick();
    chk("R11 take after second edge", takeIrq, 1);
    chk("R7 id ext", irqId, 20);
    chk("R7 sum ext", irqSummary, 32'h0010_0000);

    swReq = 32'h0000_8000;
    tick();
    chk("R7 ext overrides sw id", irqId, 20);
    chk("R7 merged summary", irqSummary, 32'h0010_8000);

    curIpl = 5'd20;
    tick();
    chk("R8 equal ipl no fire", takeIrq, 0);
    chk("R8 id held", irqId, 20);

    curIpl = 5'd0;
    cmd(1, 0, 0, 6'd25, 7'd3);
    tick();
    chk("R7 second ext level id", irqId, 25);
    chk("R7 summary three bits", irqSummary, 32'h0210_8000);

    swReq = '0;
    cmd(0, 1, 0, 6'd20, 7'd63);
    chk("R3 level emptied", levelBusy, 0);
    tick();
    chk("R3 summary drops level", irqSummary, 32'h0200_0000);

    queryLevel = 5'd25;
    cmd(1, 0, 0, 6'd25, 7'd5);
    cmd(0, 1, 0, 6'd25, 7'd3);
    chk("R3 partial clear keeps busy", levelBusy, 1);
    chk("R3 partial clear keeps pending", anyPending, 1);

    cmd(1, 1, 0, 6'd25, 7'd7);
    cmd(0, 1, 0, 6'd25, 7'd5);
    chk("R5 post wins same target", levelBusy, 1);
    cmd(0, 1, 0, 6'd25, 7'd7);
    chk("R3 last clear empties level", levelBusy, 0);
    chk("R3 nothing pending", anyPending, 0);
    tick(); tick();
    chk("R8 no fire when empty", takeIrq, 0);

    queryLevel = 5'd0;
    cmd(1, 0, 0, 6'd0, 7'd0);
    chk("R2 low level pending", anyPending, 1);
    chk("R2 low level busy", levelBusy, 1);
    tick(); tick();
    chk("R7 low level never fires", takeIrq, 0);

    queryLevel = 5'd30;
    cmd(1, 0, 1, 6'd30, 7'd1);
    chk("R4 clear-all empties", anyPending, 0);
    chk("R4 clear-all beats post", levelBusy, 0);

    cmd(1, 0, 0, 6'd32, 7'd0);
    chk("R10 bad level flagged", cmdErr, 1);
    chk("R10 bad level no state", anyPending, 0);
    queryLevel = 5'd5;
    cmd(1, 0, 0, 6'd5, 7'd64);
    chk("R10 bad source no state", levelBusy, 0);
    cmd(1, 0, 0, 6'd3, 7'd0);
    chk("R10 error sticky", cmdErr, 1);
    chk("R10 legal post still works", anyPending, 1);
    cmd(0, 0, 1, 6'd0, 7'd0);

    astReq = 1'b1;
    tick();
    chk("R9 ast flagged", astErr, 1);
    chk("R9 ast not serviced", takeIrq, 0);
    cmd(1, 0, 0, 6'd18, 7'd2);
    tick();
    chk("R9 ast does not block", takeIrq, 1);
    chk("R9 id with ast", irqId, 18);
    astReq = 1'b0;
    tick();
    chk("R9 ast flag drops", astErr, 0);

    doReset();
    chk("R10 reset clears error", cmdErr, 0);
    chk("R1 reset clears pending", anyPending, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule